// File: doc/BRIEF.md
# Non-Volatile Memory Power-State Sequencer

This block sits between a requester (a processor fetch or data-read path) and an on-chip non-volatile memory array. It tracks the array's power state and serves reads from it. After reset the array is asleep. The block holds the array in one of three resting states: sleep, standby or active. When a read arrives while the array is not active, the block wakes the array without any software action. From sleep it passes through a standby ramp and then an active ramp. From standby it goes through the active ramp only. The requester sees `req_ready` low for the whole wake-up, and the read completes only once the array is active.

While the array is active and idle, a grace timer counts down. Every served read restarts it. When the timer runs out, the array drops straight to the fallback state that software has programmed. If the fallback is active, the array stays active and later reads are served without a wake-up stall.

Software programs the fallback state and three cycle counts through a small write port. The three counts are the standby ramp, the active ramp and the grace period. The current power state and the stall length of the last completed read are driven out, so that wake-up latency can be measured. In this block, the array contents come from a behavioural stub.

Top module: `nvm_power_seq`

## Requirements
- R1: After a synchronous reset, `pwr_state` is 0 (sleep), `req_ready` is low and `stall_cycles` is 0. The fallback state resets to sleep, and the three cycle counts reset to their parameter values.
- R2: A read issued in sleep moves `pwr_state` through 4 (ramping to standby) and then 5 (ramping to active) to 3 (active), with no other code in between. The requester sees WS + WA + 2 stall edges, where WS is the standby-ramp count and WA is the active-ramp count.
- R3: A read issued in standby moves `pwr_state` through 5 to 3 and stalls for WA + 2 edges. With the default counts, this is fewer edges than a wake from sleep.
- R4: A read issued in active is served with exactly 1 stall edge and leaves `pwr_state` at 3.
- R5: `req_ready` is a one-cycle pulse, given only in active. In that cycle, `rsp_data` equals ((addr * 0x00010101) ^ 0xC3A55A3C), truncated to the data width.
- R6: The requester drops `req_valid` in the cycle after `req_ready`, and no new read follows. The power state then leaves active on the (G+1)th rising edge after the edge that raised `req_ready`, where G is the grace count. The array goes to sleep if the fallback is 0 and to standby if it is 1.
- R7: A fallback value of 3, or the reserved value 2, keeps the array active however long it is idle, and the next read stalls for 1 edge.
- R8: A write with `cfg_we` high sets one register, chosen by `cfg_sel`. Select 0 sets the fallback state from `cfg_wdata[1:0]`. Select 1 sets the standby-ramp count, select 2 the active-ramp count and select 3 the grace count. A count written as 0 acts as 1. A count takes effect when its phase next starts.
- R9: A read that arrives while the grace timer is still running is served with 1 stall edge and restarts the full grace period.
- R10: `stall_cycles` shows the number of rising edges at which `req_valid` was high and `req_ready` low for the most recently completed read. It is updated in the same cycle that `req_ready` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request, held until `req_ready` |
| req_addr | input | AW | Read address, held with `req_valid` |
| req_ready | output | 1 | One-cycle completion pulse; data valid |
| rsp_data | output | DW | Read data, valid while `req_ready` is high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 fallback, 1 standby ramp, 2 active ramp, 3 grace |
| cfg_wdata | input | TW | Configuration write value |
| pwr_state | output | 3 | 0 sleep, 1 standby, 3 active, 4 ramp to standby, 5 ramp to active |
| stall_cycles | output | SCW | Stall edges of the last completed read |

## Verification
The bench builds the block with an 8-bit address, 32-bit data, 8-bit counts, and reset counts of 12, 4 and 20 for the standby ramp, active ramp and grace period. These defaults are long enough that the ramp codes can be seen, and short enough that a full grace expiry can be waited out many times within the run. Random writes then shrink the counts to between 0 and 10. This makes zero-count clamping, one-edge ramps and grace expiries that land right next to a new read all reachable, and random fallback values cover every encoding, including the reserved one.

// File: rtl/nvm_pwr_pkg.sv
package nvm_pwr_pkg;

  typedef enum logic [2:0] {
    PS_SLEEP    = 3'd0,
    PS_STANDBY  = 3'd1,
    PS_ACTIVE   = 3'd3,
    PS_RAMP_SB  = 3'd4,
    PS_RAMP_ACT = 3'd5
  } pwr_state_e;

  localparam logic [1:0] SEL_FALLBACK = 2'd0;
  localparam logic [1:0] SEL_WAIT_SB  = 2'd1;
  localparam logic [1:0] SEL_WAIT_ACT = 2'd2;
  localparam logic [1:0] SEL_GRACE    = 2'd3;

  localparam logic [1:0] FB_SLEEP   = 2'd0;
  localparam logic [1:0] FB_STANDBY = 2'd1;

  // Behavioural array contents: a cheap address hash.
  function automatic logic [31:0] stub_word(input logic [31:0] a);
    return (a * 32'h0001_0101) ^ 32'hC3A5_5A3C;
  endfunction

endpackage

// File: rtl/nvm_pwr_cfg.sv
module nvm_pwr_cfg #(
  parameter int TW           = 8,
  parameter int WAIT_SB_RST  = 12,
  parameter int WAIT_ACT_RST = 4,
  parameter int GRACE_RST    = 20,
  parameter int FALLBACK_RST = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [TW-1:0] wdata,
  output logic [1:0]    fb_mode,
  output logic [TW-1:0] wait_sb,
  output logic [TW-1:0] wait_act,
  output logic [TW-1:0] grace
);
  import nvm_pwr_pkg::*;

  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] wval;
  assign wval = (wdata == '0) ? ONE : wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_mode  <= 2'(FALLBACK_RST);
      wait_sb  <= TW'(WAIT_SB_RST);
      wait_act <= TW'(WAIT_ACT_RST);
      grace    <= TW'(GRACE_RST);
    end else if (we) begin
      case (sel)
        SEL_FALLBACK: fb_mode  <= wdata[1:0];
        SEL_WAIT_SB:  wait_sb  <= wval;
        SEL_WAIT_ACT: wait_act <= wval;
        default:      grace    <= wval;
      endcase
    end
  end

  // R8
  wait_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (wait_sb != '0) && (wait_act != '0) && (grace != '0));

endmodule

// File: rtl/nvm_phase_timer.sv
module nvm_phase_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          tick,
  output logic          last
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= ONE;
    else if (load)
      cnt_q <= (load_val == '0) ? ONE : load_val;
    else if (tick && (cnt_q > ONE))
      cnt_q <= cnt_q - ONE;
  end

  assign last = (cnt_q == ONE);

  // R8
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (rst) cnt_q != '0);

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/nvm_data_stub.sv
module nvm_data_stub #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] rdata
);
  import nvm_pwr_pkg::*;

  logic [31:0] word;
  assign word = stub_word(32'(addr));

  always_ff @(posedge clk) begin
    if (rd_en) rdata <= word[DW-1:0];
  end

endmodule

// File: rtl/nvm_power_seq.sv
module nvm_power_seq #(
  parameter int AW           = 8,
  parameter int DW           = 32,
  parameter int TW           = 8,
  parameter int SCW          = 16,
  parameter int WAIT_SB_RST  = 12,
  parameter int WAIT_ACT_RST = 4,
  parameter int GRACE_RST    = 20,
  parameter int FALLBACK_RST = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic [AW-1:0]  req_addr,
  output logic           req_ready,
  output logic [DW-1:0]  rsp_data,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_sel,
  input  logic [TW-1:0]  cfg_wdata,
  output logic [2:0]     pwr_state,
  output logic [SCW-1:0] stall_cycles
);
  import nvm_pwr_pkg::*;

  localparam logic [SCW-1:0] SMAX = '1;

  logic [1:0]    fb_mode;
  logic [TW-1:0] wait_sb, wait_act, grace;

  nvm_pwr_cfg #(
    .TW(TW), .WAIT_SB_RST(WAIT_SB_RST), .WAIT_ACT_RST(WAIT_ACT_RST),
    .GRACE_RST(GRACE_RST), .FALLBACK_RST(FALLBACK_RST)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .fb_mode(fb_mode), .wait_sb(wait_sb), .wait_act(wait_act), .grace(grace)
  );

  pwr_state_e    state_q, state_d;
  logic          ready_q;
  logic          accept;
  logic          w_load, w_tick, w_last;
  logic [TW-1:0] w_val;
  logic          g_load, g_tick, g_last;

  assign accept = (state_q == PS_ACTIVE) && req_valid && !ready_q;
  assign w_tick = (state_q == PS_RAMP_SB) || (state_q == PS_RAMP_ACT);
  assign g_tick = (state_q == PS_ACTIVE) && !req_valid && !ready_q;
  assign g_load = accept || ((state_q == PS_RAMP_ACT) && w_last);

  always_comb begin
    state_d = state_q;
    w_load  = 1'b0;
    w_val   = wait_act;
    case (state_q)
      PS_SLEEP: if (req_valid) begin
        state_d = PS_RAMP_SB;
        w_load  = 1'b1;
        w_val   = wait_sb;
      end
      PS_STANDBY: if (req_valid) begin
        state_d = PS_RAMP_ACT;
        w_load  = 1'b1;
      end
      PS_RAMP_SB: if (w_last) begin
        state_d = PS_RAMP_ACT;
        w_load  = 1'b1;
      end
      PS_RAMP_ACT: if (w_last) state_d = PS_ACTIVE;
      PS_ACTIVE: if (g_tick && g_last) begin
        if (fb_mode == FB_SLEEP)        state_d = PS_SLEEP;
        else if (fb_mode == FB_STANDBY) state_d = PS_STANDBY;
      end
      default: state_d = PS_SLEEP;
    endcase
  end

  nvm_phase_timer #(.TW(TW)) u_wake (
    .clk(clk), .rst(rst), .load(w_load), .load_val(w_val),
    .tick(w_tick), .last(w_last)
  );

  nvm_phase_timer #(.TW(TW)) u_grace (
    .clk(clk), .rst(rst), .load(g_load), .load_val(grace),
    .tick(g_tick), .last(g_last)
  );

  nvm_data_stub #(.AW(AW), .DW(DW)) u_stub (
    .clk(clk), .rd_en(accept), .addr(req_addr), .rdata(rsp_data)
  );

  logic [SCW-1:0] run_q, last_q, run_inc;
  assign run_inc = (run_q == SMAX) ? SMAX : run_q + SCW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_SLEEP;
      ready_q <= 1'b0;
      run_q   <= '0;
      last_q  <= '0;
    end else begin
      state_q <= state_d;
      ready_q <= accept;
      if (accept) begin
        last_q <= run_inc;
        run_q  <= '0;
      end else if (req_valid && !ready_q) begin
        run_q  <= run_inc;
      end
    end
  end

  assign req_ready    = ready_q;
  assign pwr_state    = state_q;
  assign stall_cycles = last_q;

  // R5
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready);

  // R5
  ready_active_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (pwr_state == 3'd3));

  // R2
  sleep_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 3'd0) |=> ((pwr_state == 3'd0) || (pwr_state == 3'd4)));

  // R2
  ramp_sb_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 3'd4) |=> ((pwr_state == 3'd4) || (pwr_state == 3'd5)));

  // R3
  ramp_act_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 3'd5) |=> ((pwr_state == 3'd5) || (pwr_state == 3'd3)));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((pwr_state == 3'd3) && req_valid) |=> (pwr_state == 3'd3));

  // R7
  fb_active_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((pwr_state == 3'd3) && fb_mode[1]) |=> (pwr_state == 3'd3));

endmodule

// File: tb/nvm_power_seq_test.sv
module nvm_power_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8, DW = 32, TW = 8, SCW = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           req_valid = 1'b0;
  logic [AW-1:0]  req_addr = '0;
  logic           req_ready;
  logic [DW-1:0]  rsp_data;
  logic           cfg_we = 1'b0;
  logic [1:0]     cfg_sel = '0;
  logic [TW-1:0]  cfg_wdata = '0;
  logic [2:0]     pwr_state;
  logic [SCW-1:0] stall_cycles;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_power_seq #(
    .AW(AW), .DW(DW), .TW(TW), .SCW(SCW), .WAIT_SB_RST(12),
    .WAIT_ACT_RST(4), .GRACE_RST(20), .FALLBACK_RST(0)
  ) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_data(rsp_data), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .pwr_state(pwr_state),
    .stall_cycles(stall_cycles)
  );

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  // reference model of the requirements
  int m_state = 0;
  int m_left  = 1;
  int m_fb    = 0;
  int m_wsb   = 12;
  int m_wact  = 4;
  int m_grace = 20;

  function automatic logic [31:0] exp_data(input logic [AW-1:0] a);
    return (32'(a) * 32'h0001_0101) ^ 32'hC3A5_5A3C;
  endfunction

  function automatic int exp_stall(input int st);
    if (st == 0) return m_wsb + m_wact + 2;
    if (st == 1) return m_wact + 2;
    return 1;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one idle rising edge in the model
  task automatic model_edge();
    if (m_state == 3) begin
      if (m_left <= 1 && m_fb < 2) m_state = m_fb;
      else if (m_left > 1) m_left--;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      model_edge();
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input int val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = TW'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    model_edge();
    case (sel)
      2'd0: m_fb = val & 3;
      2'd1: m_wsb = (val == 0) ? 1 : val;
      2'd2: m_wact = (val == 0) ? 1 : val;
      default: m_grace = (val == 0) ? 1 : val;
    endcase
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    int k = 0;
    int bad = 0;
    int prev = m_state;
    int start = m_state;
    int exp = exp_stall(m_state);
    string tg;
    tg = (start == 0) ? "R2" : (start == 1) ? "R3" : "R4";
    req_valid = 1'b1; req_addr = a;
    forever begin
      @(negedge clk);
      k++;
      if (int'(pwr_state) != prev) begin
        if (!((prev == 0 && pwr_state == 4) || (prev == 4 && pwr_state == 5) ||
              (prev == 1 && pwr_state == 5) || (prev == 5 && pwr_state == 3)))
          bad++;
        prev = int'(pwr_state);
      end
      if (req_ready || k > 2000) break;
    end
    chk({tg, " stall edges"}, k, exp);
    chk({tg, " state path"}, bad, 0);
    chk("R10 stall_cycles", stall_cycles, exp);
    chk("R5 rsp_data", rsp_data, exp_data(a));
    chk("R5 state at ready", pwr_state, 3);
    req_valid = 1'b0;
    m_state = 3;
    m_left = m_grace + 1;
    @(negedge clk);
    model_edge();
    chk("R5 ready pulse", req_ready, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 pwr_state", pwr_state, 0);
    chk("R1 req_ready", req_ready, 0);
    chk("R1 stall_cycles", stall_cycles, 0);
    idle(5);
    chk("R1 stays asleep", pwr_state, 0);

    // R2 wake from sleep with default counts
    do_read(8'h12);
    // R6 grace expiry, default 20
    idle(m_grace - 1);
    chk("R6 active before expiry", pwr_state, 3);
    idle(1);
    chk("R6 dropped to sleep", pwr_state, 0);

    // R8 reprogram, R3 standby wake
    cfg_write(2'd0, 1);
    cfg_write(2'd1, 3);
    cfg_write(2'd2, 2);
    cfg_write(2'd3, 5);
    do_read(8'h00);
    chk("R8 ramp counts R2", stall_cycles, 7);
    idle(5);
    chk("R6 dropped to standby", pwr_state, 1);
    do_read(8'hFF);
    chk("R3 standby stall", stall_cycles, 4);
    do_read(8'h7E);
    chk("R4 active stall", stall_cycles, 1);

    // R9 late read restarts grace
    idle(4);
    chk("R9 still active", pwr_state, 3);
    do_read(8'h33);
    idle(4);
    chk("R9 grace restarted", pwr_state, 3);
    idle(1);
    chk("R9 expiry after restart", pwr_state, 1);

    // R8 zero count acts as one
    cfg_write(2'd2, 0);
    do_read(8'h44);
    chk("R8 zero count", stall_cycles, 3);

    // R7 fallback active and reserved value
    cfg_write(2'd0, 2);
    idle(30);
    chk("R7 reserved stays active", pwr_state, 3);
    do_read(8'h55);
    chk("R7 no wake stall", stall_cycles, 1);
    cfg_write(2'd0, 3);
    idle(30);
    chk("R7 active fallback", pwr_state, 3);
    cfg_write(2'd0, 0);
    idle(2);
    chk("R6 late fallback to sleep", pwr_state, 0);

    // random phase
    for (int it = 0; it < 300; it++) begin
      int r = int'($urandom % 10);
      if (r < 4) begin
        do_read(AW'($urandom));
      end else if (r < 7) begin
        idle(1 + int'($urandom % 25));
      end else begin
        logic [1:0] s = 2'($urandom);
        int v = (s == 2'd0) ? int'($urandom % 4) :
                (s == 2'd3) ? int'($urandom % 11) : int'($urandom % 7);
        cfg_write(s, v);
      end
      chk("R6 R7 state model", pwr_state, m_state);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule